// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Converters

This block is a purely combinational binary adder. It takes two operands and a carry-in, and it returns their sum together with a carry-out. The operand bits are cut into groups that widen toward the most significant end. The lowest group is a plain ripple-carry adder fed by the external carry-in.

Every group above the lowest one speculates on its incoming carry. A ripple-carry adder computes the group result as if that carry were 0. A separate increment-by-one converter, one bit wider than the group, turns that result into the value the group would have if the carry were 1. When the real carry from the group below arrives, a multiplexer picks one of the two results. The picked carry then selects in the next group, so the critical path runs along the chain of multiplexers and not along every full adder.

The group widths are a parameter list. An elaboration-time check rejects any list whose widths do not add up to the adder width. The block has no clock and no state. It is meant to sit inside a registered datapath stage.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input, the 65-bit value {carry_out, sum_out} equals op_a + op_b + carry_in.
- R2: The lowest group is a ripple adder that adds op_a[1:0], op_b[1:0] and carry_in. It produces sum_out[1:0] and the carry passed to the group above, so carry_in = 1 with op_a = 3 and op_b = 0 gives a sum of 4.
- R3: Each higher group of width n has one ripple adder whose carry input is 0. It yields an n-bit partial sum and a carry equal to the group slices of op_a and op_b added without any incoming carry.
- R4: Each higher group forms its carry-is-1 result with an (n+1)-bit increment converter applied to {zero-carry carry, zero-carry sum}. Output bit 0 is the inverse of input bit 0. Output bit i is input bit i XOR the AND of all lower input bits, so an all-ones input wraps to all zeros.
- R5: In each higher group, a multiplexer passes the zero-carry result (sum and carry) when the carry from the group below is 0. It passes the converter output when that carry is 1.
- R6: The selected carry of each group is the select for the next group. The selected carry of the top group is carry_out.
- R7: The group widths come from the parameter GROUP_W, listed from the least significant group upward. The default list is 2,2,3,4,5,6,7,8,9,11,7 for WIDTH = 64. Elaboration fails when the listed widths do not sum to WIDTH. A carry entering any of the 64 bit positions reaches its proper place.
- R8: All-ones plus 1 with carry_in 0 gives sum_out = 0 and carry_out = 1.
- R9: All-ones plus all-ones with carry_in 1 gives sum_out all ones and carry_out = 1.
- R10: Zero plus zero with carry_in 0 gives sum_out = 0 and carry_out = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH (64) | First operand |
| op_b | input | WIDTH (64) | Second operand |
| carry_in | input | 1 | Carry into the least significant bit |
| sum_out | output | WIDTH (64) | Sum bits |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
A fault inside one group shows at the ports in the same evaluation as the inputs that expose it, because there are no registers. The fault shows only when the operands drive that group's incoming carry to the value that picks the faulty path. A broken converter stays hidden until a carry of 1 enters its group. A broken zero-carry adder shows up through both paths, since the converter is built on its output. A wrong select polarity corrupts every vector in which the lower carry is set. Operands that force carries across every boundary at once are therefore added to random vectors, along with patterns that stop all carries.

// File: rtl/csel_pkg.sv
// Package csel_pkg
// Shared types and elaboration-time helpers for the carry-select adder.
// Assumes no more than MAX_GROUPS groups; unused list entries are zero.
package csel_pkg;

    localparam int MAX_GROUPS = 16;

    typedef int unsigned width_list_t [MAX_GROUPS];

    // Bit position at which group idx starts (sum of all lower widths).
    function automatic int unsigned group_base(input width_list_t wl, input int idx);
        int unsigned acc;
        acc = 0;
        for (int k = 0; k < MAX_GROUPS; k++) begin
            if (k < idx) acc += wl[k];
        end
        return acc;
    endfunction

    // Total width covered by the first cnt groups.
    function automatic int unsigned group_total(input width_list_t wl, input int cnt);
        return group_base(wl, cnt);
    endfunction

    // Widest group in the first cnt groups.
    function automatic int unsigned group_widest(input width_list_t wl, input int cnt);
        int unsigned best;
        best = 0;
        for (int k = 0; k < MAX_GROUPS; k++) begin
            if (k < cnt && wl[k] > best) best = wl[k];
        end
        return best;
    endfunction

endpackage

// File: rtl/csel_full_add.sv
// Module csel_full_add
// One-bit full adder cell used to build the ripple chains.
// Assumes nothing beyond single-bit inputs.
module csel_full_add (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    logic half;

    // Propagate term, shared by sum and carry.
    assign half = x_i ^ y_i;

    // Sum and majority carry.
    always_comb begin
        s_o = half ^ c_i;
        c_o = (x_i & y_i) | (c_i & half);
    end

endmodule

// File: rtl/csel_ripple.sv
// Module csel_ripple
// Ripple-carry adder of W bits built from full-adder cells.
// Assumes W >= 1; carry enters at bit 0 and leaves above bit W-1.
module csel_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);

    logic [W:0] chain;

    // Carry entry point of the chain.
    assign chain[0] = c_i;

    // One cell per bit, carry passed upward.
    for (genvar i = 0; i < W; i++) begin : g_bit
        csel_full_add u_fa (
            .x_i (x_i[i]),
            .y_i (y_i[i]),
            .c_i (chain[i]),
            .s_o (s_o[i]),
            .c_o (chain[i+1])
        );
    end

    // Carry leaving the top cell.
    assign c_o = chain[W];

endmodule

// File: rtl/csel_excess1.sv
// Module csel_excess1
// Binary to excess-1 converter: returns the input plus one, modulo 2^W.
// Built from a prefix AND chain and XOR gates, with no full adders.
// Assumes W >= 1.
module csel_excess1 #(
    parameter int W = 5
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] inc_o
);

    logic [W:0] all_low;

    // The empty AND below bit 0 is 1, so bit 0 simply inverts.
    assign all_low[0] = 1'b1;

    // Each bit toggles when every lower input bit is set.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign all_low[i+1] = all_low[i] & bin_i[i];
        assign inc_o[i]     = bin_i[i] ^ all_low[i];
    end

endmodule

// File: rtl/csel_select.sv
// Module csel_select
// 2W:W multiplexer that picks between the zero-carry and one-carry results.
// Assumes sel_i is the real carry coming from the group below.
module csel_select #(
    parameter int W = 5
) (
    input  logic [W-1:0] zero_i,
    input  logic [W-1:0] one_i,
    input  logic         sel_i,
    output logic [W-1:0] pick_o
);

    // Choose the speculative result that matches the incoming carry.
    always_comb begin
        if (sel_i) pick_o = one_i;
        else       pick_o = zero_i;
    end

endmodule

// File: rtl/sqrt_csel_adder.sv
// Module sqrt_csel_adder
// Combinational carry-select adder with groups that widen upward. Group 0
// ripples the external carry. Every higher group ripples with carry 0,
// increments that result with an excess-1 converter, and selects with the
// carry from the group below.
// Assumes the first NUM_GROUPS entries of GROUP_W sum to WIDTH; this is
// checked at elaboration.
module sqrt_csel_adder
    import csel_pkg::*;
#(
    parameter int          WIDTH      = 64,
    parameter int          NUM_GROUPS = 11,
    parameter width_list_t GROUP_W    = '{2, 2, 3, 4, 5, 6, 7, 8, 9, 11, 7,
                                          0, 0, 0, 0, 0}
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int COVERED = int'(group_total(GROUP_W, NUM_GROUPS));
    localparam int WIDEST  = int'(group_widest(GROUP_W, NUM_GROUPS));

    // Elaboration-time checks on the width list.
    if (NUM_GROUPS < 1 || NUM_GROUPS > MAX_GROUPS) begin : g_bad_count
        $error("sqrt_csel_adder: NUM_GROUPS out of range");
    end
    if (COVERED != WIDTH) begin : g_bad_sum
        $error("sqrt_csel_adder: group widths do not add up to WIDTH");
    end
    if (WIDEST < 1) begin : g_bad_width
        $error("sqrt_csel_adder: empty group width list");
    end

    // Flattened per-group intermediates. The assertion checker reads them.
    logic [WIDTH-1:0]      zero_sum;
    logic [NUM_GROUPS-1:0] zero_cry;
    logic [WIDTH-1:0]      inc_sum;
    logic [NUM_GROUPS-1:0] inc_cry;
    logic [NUM_GROUPS-1:0] grp_cry;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int BASE = int'(group_base(GROUP_W, g));
        localparam int GW   = int'(GROUP_W[g]);

        if (g == 0) begin : g_low
            logic [GW-1:0] low_sum;
            logic          low_cry;

            // Lowest group ripples the real carry-in.
            csel_ripple #(.W(GW)) u_rca (
                .x_i (op_a[BASE +: GW]),
                .y_i (op_b[BASE +: GW]),
                .c_i (carry_in),
                .s_o (low_sum),
                .c_o (low_cry)
            );

            // The lowest group has no speculation, so both slots carry its result.
            assign zero_sum[BASE +: GW] = low_sum;
            assign zero_cry[g]          = low_cry;
            assign inc_sum[BASE +: GW]  = low_sum;
            assign inc_cry[g]           = low_cry;
            assign sum_out[BASE +: GW]  = low_sum;
            assign grp_cry[g]           = low_cry;
        end else begin : g_spec
            logic [GW-1:0] rc_sum;
            logic          rc_cry;
            logic [GW:0]   ex_out;
            logic [GW:0]   pick;

            // Zero-carry ripple adder for this group.
            csel_ripple #(.W(GW)) u_rca (
                .x_i (op_a[BASE +: GW]),
                .y_i (op_b[BASE +: GW]),
                .c_i (1'b0),
                .s_o (rc_sum),
                .c_o (rc_cry)
            );

            // One-carry result: the zero-carry result plus one.
            csel_excess1 #(.W(GW + 1)) u_bec (
                .bin_i ({rc_cry, rc_sum}),
                .inc_o (ex_out)
            );

            // Carry from the group below picks the result.
            csel_select #(.W(GW + 1)) u_mux (
                .zero_i ({rc_cry, rc_sum}),
                .one_i  (ex_out),
                .sel_i  (grp_cry[g-1]),
                .pick_o (pick)
            );

            assign zero_sum[BASE +: GW] = rc_sum;
            assign zero_cry[g]          = rc_cry;
            assign inc_sum[BASE +: GW]  = ex_out[GW-1:0];
            assign inc_cry[g]           = ex_out[GW];
            assign sum_out[BASE +: GW]  = pick[GW-1:0];
            assign grp_cry[g]           = pick[GW];
        end
    end

    // The top group's selected carry leaves the adder.
    assign carry_out = grp_cry[NUM_GROUPS-1];

endmodule

// File: rtl/sqrt_csel_adder_chk.sv
// Module sqrt_csel_adder_chk
// Assertion checker bound into sqrt_csel_adder. It checks each group's
// speculative paths and the carry chain against arithmetic references.
// Assumes settled combinational inputs at evaluation.
module sqrt_csel_adder_chk
    import csel_pkg::*;
#(
    parameter int          WIDTH      = 64,
    parameter int          NUM_GROUPS = 11,
    parameter width_list_t GROUP_W    = '{2, 2, 3, 4, 5, 6, 7, 8, 9, 11, 7,
                                          0, 0, 0, 0, 0}
) (
    input logic [WIDTH-1:0]      op_a,
    input logic [WIDTH-1:0]      op_b,
    input logic                  carry_in,
    input logic [WIDTH-1:0]      sum_out,
    input logic                  carry_out,
    input logic [WIDTH-1:0]      zero_sum,
    input logic [NUM_GROUPS-1:0] zero_cry,
    input logic [WIDTH-1:0]      inc_sum,
    input logic [NUM_GROUPS-1:0] inc_cry,
    input logic [NUM_GROUPS-1:0] grp_cry
);

    localparam int XW = WIDTH + 1;

    // Whole-word result against the arithmetic reference.
    always_comb begin
        AST_SUM_EXACT: assert ({carry_out, sum_out} ==
                               ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in})); // R1
        AST_COUT_TOP: assert (carry_out == grp_cry[NUM_GROUPS-1]); // R6
    end

    // Per-group checks on the zero path, the increment path and the selection.
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            automatic int          base = int'(group_base(GROUP_W, g));
            automatic int          gw   = int'(GROUP_W[g]);
            automatic logic [XW-1:0] mask  = ({{(XW-1){1'b0}}, 1'b1} << gw) - 1'b1;
            automatic logic [XW-1:0] mask1 = (mask << 1) | {{(XW-1){1'b0}}, 1'b1};
            automatic logic [XW-1:0] as_g  = ({1'b0, op_a} >> base) & mask;
            automatic logic [XW-1:0] bs_g  = ({1'b0, op_b} >> base) & mask;
            automatic logic [XW-1:0] ss_g  = ({1'b0, sum_out} >> base) & mask;
            automatic logic [XW-1:0] zs_g  = ({1'b0, zero_sum} >> base) & mask;
            automatic logic [XW-1:0] is_g  = ({1'b0, inc_sum} >> base) & mask;
            automatic logic [XW-1:0] zfull = zs_g | ({{(XW-1){1'b0}}, zero_cry[g]} << gw);
            automatic logic [XW-1:0] ifull = is_g | ({{(XW-1){1'b0}}, inc_cry[g]} << gw);
            automatic logic [XW-1:0] sfull = ss_g | ({{(XW-1){1'b0}}, grp_cry[g]} << gw);
            automatic logic          c_below = (g == 0) ? carry_in : grp_cry[(g == 0) ? 0 : g - 1];
            if (g == 0) begin
                AST_LOW_GROUP: assert (sfull == as_g + bs_g + {{(XW-1){1'b0}}, carry_in}); // R2
            end else begin
                AST_ZERO_PATH: assert (zfull == as_g + bs_g); // R3
                AST_INCREMENT: assert (ifull == ((zfull + 1'b1) & mask1)); // R4
                AST_SELECT: assert (sfull == (c_below ? ifull : zfull)); // R5
            end
            AST_GROUP_CHAIN: assert (sfull == as_g + bs_g + {{(XW-1){1'b0}}, c_below}); // R6
        end
    end

endmodule

bind sqrt_csel_adder sqrt_csel_adder_chk #(
    .WIDTH      (WIDTH),
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W)
) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .zero_sum  (zero_sum),
    .zero_cry  (zero_cry),
    .inc_sum   (inc_sum),
    .inc_cry   (inc_cry),
    .grp_cry   (grp_cry)
);

// File: tb/sqrt_csel_adder_tb_top.sv
// Bench for sqrt_csel_adder. It walks a table of directed vectors, then
// runs a carry-position sweep and random vectors. The reference is the
// plain 65-bit sum of the inputs.
module sqrt_csel_adder_tb_top;

    localparam int W    = 64;
    localparam int NVEC = 9;
    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] ALT5 = {(W/2){2'b01}};
    localparam logic [W-1:0] ALTA = {(W/2){2'b10}};
    localparam logic [W-1:0] TOPB = {1'b1, {(W-1){1'b0}}};

    // Each row is {op_a, op_b, carry_in}.
    localparam logic [2*W:0] VEC [NVEC] = '{
        {{W{1'b0}}, {W{1'b0}}, 1'b0},             // R10 zero plus zero
        {ONES, {{(W-1){1'b0}}, 1'b1}, 1'b0},      // R8 all ones plus one
        {ONES, ONES, 1'b1},                       // R9 all ones twice plus carry
        {ALT5, ALTA, 1'b0},                       // R3 no carry anywhere
        {ALT5, ALTA, 1'b1},                       // R4 carry through every converter
        {ALTA, ALTA, 1'b0},                       // R5 carries at every other bit
        {{{(W-2){1'b0}}, 2'b11}, {W{1'b0}}, 1'b1},// R2 carry out of lowest group
        {TOPB, TOPB, 1'b0},                       // R6 top carry only
        {{W{1'b0}}, {W{1'b0}}, 1'b1}              // R2 carry-in alone
    };
    localparam string TAGS [NVEC] = '{"R10", "R8", "R9", "R3", "R4", "R5", "R2", "R6", "R2"};

    logic         clk;
    logic         rst_n;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic         carry_in;
    logic [W-1:0] sum_out;
    logic         carry_out;

    int n_checks;
    int n_fails;

    sqrt_csel_adder dut_i (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    // 100 MHz clock.
    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Apply one vector at a falling edge and compare one step later.
    task automatic apply_check(input string tag, input logic [W-1:0] a,
                               input logic [W-1:0] b, input logic c);
        logic [W:0] expv;
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        carry_in = c;
        #1;
        expv = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        n_checks++;
        if ({carry_out, sum_out} !== expv) begin
            n_fails++;
            $display("FAIL %s: a=%h b=%h cin=%b got=%h expected=%h",
                     tag, a, b, c, {carry_out, sum_out}, expv);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        n_checks = 0;
        n_fails  = 0;
        rst_n    = 1'b0;
        op_a     = '0;
        op_b     = '0;
        carry_in = 1'b0;

        // Reset state: idle zero inputs give zero outputs (R10).
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (sum_out !== '0 || carry_out !== 1'b0) begin
            n_fails++;
            $display("FAIL R10 reset: got=%h expected=0", {carry_out, sum_out});
        end
        rst_n = 1'b1;

        // Directed table.
        for (int i = 0; i < NVEC; i++) begin
            apply_check(TAGS[i], VEC[i][2*W:W+1], VEC[i][W:1], VEC[i][0]);
        end

        // A carry entering each bit position (R7 partition covers all bits).
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] lowones;
            lowones = ({{(W-1){1'b0}}, 1'b1} << k) - 1'b1;
            apply_check("R7", lowones, {{(W-1){1'b0}}, 1'b1}, 1'b0);
            apply_check("R7", lowones, {W{1'b0}}, 1'b1);
        end

        // Ones that stop at each position, carry in from below (R5 and R6).
        for (int k = 1; k < W; k++) begin
            apply_check("R6", ONES >> k, ONES >> k, 1'b1);
        end

        // Random operands (R1).
        for (int i = 0; i < 3000; i++) begin
            apply_check("R1", {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule